// File: doc/BRIEF.md
# Converter Sample Clock Divider

This block turns a fast peripheral clock into the timing strobes that pace an analog-to-digital converter controller. The input clock is first halved by a fixed stage. Two further stages follow: an optional programmable prescaler and a programmable scaler. The outputs are not derived clocks. They are single-cycle enable pulses in the input clock domain: a conversion tick, and a sample tick that marks the end of every twelfth conversion tick.

Both divisors live in one 32-bit control register, which is written through a small write port at byte offset 0x0C. A build parameter picks the field layout. The legacy layout has a 15-bit prescaler and a 10-bit scaler. The newer layout has a single 16-bit scaler and no prescaler. A new divisor is adopted by each stage only at that stage's terminal count, so no shortened pulse interval ever appears.

Top module: `adc_sample_clkdiv`

## Requirements
- R1: While rst_ni is low, conv_tick_o and sample_tick_o are 0. With all divider fields at zero, conv_tick_o is 1 in the cycle after the first rising clock edge that follows reset release, and then recurs every 2 cycles.
- R2: With LEGACY_LAYOUT=1, conv_tick_o recurs every 2 × (P+1) × (S+1) input cycles, where P is control bits [31:17] and S is control bits [9:0].
- R3: With LEGACY_LAYOUT=0, conv_tick_o recurs every 2 × (S+1) input cycles, where S is control bits [15:0].
- R4: With LEGACY_LAYOUT=1, control bits [16:10] have no effect on the tick period.
- R5: With LEGACY_LAYOUT=0, control bits [31:16] have no effect on the tick period.
- R6: sample_tick_o is 1 only in a cycle where conv_tick_o is 1, and exactly 12 conversion ticks occur from one sample tick up to and including the next.
- R7: Only a write with cfg_we_i=1 and cfg_addr_i=0x0C changes the divisors. A write to any other address leaves the period unchanged.
- R8: A new divisor takes effect only at the terminal count of its stage. The interval in progress when the write lands completes at its old length.
- R9: Each output pulse lasts exactly one cycle. conv_tick_o is never 1 in two consecutive cycles.
- R10: Asserting rst_ni clears the divider fields and all counters. After release, the R1 timing holds regardless of the earlier settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register byte address |
| cfg_wdata_i | input | 32 | Register write data |
| conv_tick_o | output | 1 | Single-cycle conversion clock enable |
| sample_tick_o | output | 1 | Single-cycle enable, once per 12 conversion ticks |

## Verification
The bench builds two instances side by side, one with LEGACY_LAYOUT=1 and one with LEGACY_LAYOUT=0, so both field layouts are exercised in one run. The legacy instance brings the product of prescaler and scaler, and the ignored gap bits between the two fields, within reach. The newer instance brings the wide single scaler and its ignored upper half within reach. Because the newer instance has only one programmable stage, the interval in progress during a write has an exact length, and that instance carries the check that a divisor change waits for the terminal count.

// File: rtl/adc_clkdiv_pkg.sv
package adc_clkdiv_pkg;
  localparam int CTRL_W          = 32;
  localparam int LEG_PRE_LSB     = 17;
  localparam int LEG_PRE_W       = 15;
  localparam int LEG_SCL_W       = 10;
  localparam int NEW_SCL_W       = 16;
  localparam int CONV_PER_SAMPLE = 12;

  function automatic int scl_width(bit legacy);
    return legacy ? LEG_SCL_W : NEW_SCL_W;
  endfunction
endpackage

// File: rtl/acd_half_stage.sv
module acd_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t_q <= 1'b0;
    else         t_q <= ~t_q;
  end

  assign tick_o = t_q;

  assert_half_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/acd_div_stage.sv
module acd_div_stage #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, div_q;
  logic         term;

  assign term = tick_i && (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == div_q) begin
        cnt_q <= '0;
        div_q <= div_i;   // new divisor only at terminal count
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = term;

  assert_cnt_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_q);
  assert_div_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term |=> $stable(div_q));
endmodule

// File: rtl/acd_sample_stage.sv
module acd_sample_stage #(
  parameter int N = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tick_o
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = tick_i && (cnt_q == LAST);

  assert_sample_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_sample_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/adc_sample_clkdiv.sv
module adc_sample_clkdiv
  import adc_clkdiv_pkg::*;
#(
  parameter bit          LEGACY_LAYOUT = 1'b1,
  parameter int          ADDR_W        = 8,
  parameter int          CTRL_ADDR     = 'h0C,
  parameter int          SAMPLE_DIV    = CONV_PER_SAMPLE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic              conv_tick_o,
  output logic              sample_tick_o
);
  localparam int SCL_W = scl_width(LEGACY_LAYOUT);

  logic             ctrl_wr;
  logic             half_tick, pre_tick, conv_tick;
  logic [SCL_W-1:0] scl_q;
  logic             unused_wdata;

  assign ctrl_wr      = cfg_we_i && (cfg_addr_i == ADDR_W'(CTRL_ADDR));
  assign unused_wdata = ^cfg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      scl_q <= '0;
    else if (ctrl_wr) scl_q <= cfg_wdata_i[SCL_W-1:0];
  end

  acd_half_stage u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (half_tick)
  );

  generate
    if (LEGACY_LAYOUT) begin : g_pre
      logic [LEG_PRE_W-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pre_q <= '0;
        else if (ctrl_wr) pre_q <= cfg_wdata_i[LEG_PRE_LSB +: LEG_PRE_W];
      end

      acd_div_stage #(.W(LEG_PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (half_tick),
        .div_i  (pre_q),
        .tick_o (pre_tick)
      );

      assert_pre_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> $stable(pre_q));
    end else begin : g_nopre
      assign pre_tick = half_tick;
    end
  endgenerate

  acd_div_stage #(.W(SCL_W)) u_scl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (pre_tick),
    .div_i  (scl_q),
    .tick_o (conv_tick)
  );

  acd_sample_stage #(.N(SAMPLE_DIV)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (conv_tick),
    .tick_o (sample_tick_o)
  );

  assign conv_tick_o = conv_tick;

  assert_scl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(scl_q));
  assert_conv_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_tick_o |=> !conv_tick_o);
  assert_sample_on_conv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |-> conv_tick_o);
endmodule

// File: tb/sim_adc_sample_clkdiv.sv
module sim_adc_sample_clkdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [7:0]  ad0 = '0, ad1 = '0;
  logic [31:0] wd0 = '0, wd1 = '0;
  logic        conv0, samp0, conv1, samp1;
  int          n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_sample_clkdiv #(.LEGACY_LAYOUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we0), .cfg_addr_i(ad0),
    .cfg_wdata_i(wd0), .conv_tick_o(conv0), .sample_tick_o(samp0));

  adc_sample_clkdiv #(.LEGACY_LAYOUT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we1), .cfg_addr_i(ad1),
    .cfg_wdata_i(wd1), .conv_tick_o(conv1), .sample_tick_o(samp1));

  localparam int LEG_N = 6;
  localparam int LEG_PRE [LEG_N]  = '{0, 1, 0, 2, 4, 3};
  localparam int LEG_SCL [LEG_N]  = '{0, 0, 1, 3, 2, 9};
  localparam int LEG_GAP [LEG_N]  = '{0, 127, 0, 21, 0, 42};
  localparam int NEW_N = 4;
  localparam int NEW_SCL [NEW_N]  = '{0, 1, 5, 37};
  localparam int NEW_HIGH [NEW_N] = '{0, 65535, 4660, 0};

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic conv_of(input int sel);
    return (sel != 0) ? conv1 : conv0;
  endfunction

  task automatic write_cfg(input int sel, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (sel != 0) begin we1 = 1'b1; ad1 = a; wd1 = d; end
    else          begin we0 = 1'b1; ad0 = a; wd0 = d; end
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic wait_tick(input int sel);
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (conv_of(sel)) break;
    end
  endtask

  task automatic measure(input int sel, output int per);
    wait_tick(sel);
    per = 0;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      per++;
      if (conv_of(sel)) break;
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int per, cnt;
    logic [31:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 conv0 in reset", int'(conv0), 0);
    check("R1 samp0 in reset", int'(samp0), 0);
    check("R1 conv1 in reset", int'(conv1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 conv0 first edge", int'(conv0), 1);
    check("R1 conv1 first edge", int'(conv1), 1);
    @(negedge clk);
    check("R9 conv0 single cycle", int'(conv0), 0);
    measure(0, per);
    check("R1 default period", per, 2);

    // R2 R4: legacy table
    for (int i = 0; i < LEG_N; i++) begin
      d = (32'(LEG_PRE[i]) << 17) | (32'(LEG_GAP[i]) << 10) | 32'(LEG_SCL[i]);
      write_cfg(0, 8'h0C, d);
      measure(0, per);
      measure(0, per);
      check((LEG_GAP[i] != 0) ? "R4 legacy gap bits" : "R2 legacy period",
            per, 2 * (LEG_PRE[i] + 1) * (LEG_SCL[i] + 1));
    end

    // R3 R5: newer layout table
    for (int i = 0; i < NEW_N; i++) begin
      d = (32'(NEW_HIGH[i]) << 16) | 32'(NEW_SCL[i]);
      write_cfg(1, 8'h0C, d);
      measure(1, per);
      measure(1, per);
      check((NEW_HIGH[i] != 0) ? "R5 upper bits" : "R3 new period",
            per, 2 * (NEW_SCL[i] + 1));
    end

    // R7: other address ignored (u0 is at period 80)
    write_cfg(0, 8'h08, 32'h0000_0001);
    measure(0, per);
    measure(0, per);
    check("R7 wrong address", per, 80);
    write_cfg(1, 8'h10, 32'h0000_0000);
    measure(1, per);
    check("R7 wrong address new", per, 76);

    // R6: 12 conversion ticks per sample tick
    write_cfg(0, 8'h0C, 32'h0000_0001);
    measure(0, per);
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (samp0) break;
    end
    check("R6 sample with conv", int'(conv0), 1);
    cnt = 0;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (conv0) cnt++;
      if (samp0) break;
    end
    check("R6 conv per sample", cnt, 12);

    // R8: change lands only at terminal count (u1)
    write_cfg(1, 8'h0C, 32'd9);
    measure(1, per);
    measure(1, per);
    check("R8 setup period", per, 20);
    wait_tick(1);
    @(negedge clk);
    @(negedge clk);
    we1 = 1'b1; ad1 = 8'h0C; wd1 = 32'd2;
    @(negedge clk);
    we1 = 1'b0;
    per = 3;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      per++;
      if (conv1) break;
    end
    check("R8 interval in progress", per, 20);
    per = 0;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      per++;
      if (conv1) break;
    end
    check("R8 next interval", per, 6);

    // R10: reset clears fields
    write_cfg(0, 8'h0C, (32'd2 << 17) | 32'd3);
    measure(0, per);
    measure(0, per);
    check("R10 before reset", per, 24);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 conv0 in reset", int'(conv0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 first tick", int'(conv0), 1);
    measure(0, per);
    check("R10 period after reset", per, 2);
    measure(1, per);
    check("R10 new period after reset", per, 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule